// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block sends one SD command on the CMD line and collects the card's reply. Software first writes a 32-bit argument and then a command word. The command word holds a 6-bit command index and a set of flag bits. When the start bit of that word is set, the engine builds a 48-bit command frame with its CRC7 and shifts it out most significant bit first. It then does one of three things, chosen by the flags: it finishes at once, it waits for a 48-bit reply, or it waits for a 136-bit reply. A further flag makes it wait, after a good reply, until the card releases DAT0.

The reply is placed in four 32-bit response registers. Three outcomes are recorded as write-one-to-clear status bits: a reply that never came, a bad reply CRC, and the end of card busy. Either error also sets a sticky failed bit in the command word. That bit stays set until the next command starts.

All protocol activity moves only on cycles where `sd_tick` is high. `sd_tick` is a clock enable that marks each SD clock period. Register writes are taken on any cycle.

The controller has five states:
- `ST_IDLE`: waits for a start.
- `ST_SEND`: shifts out the frame.
- `ST_WAIT`: waits for the reply start bit, counting toward the timeout.
- `ST_RECV`: shifts in the reply.
- `ST_BUSY`: waits for DAT0 to go high.

Its transitions are:
- start: `ST_IDLE` to `ST_SEND`.
- frame sent with no reply expected: `ST_SEND` to `ST_IDLE`.
- frame sent with a reply expected: `ST_SEND` to `ST_WAIT`.
- low start bit seen: `ST_WAIT` to `ST_RECV`.
- timeout: `ST_WAIT` to `ST_IDLE`.
- last reply bit taken, with a CRC error or no busy wait: `ST_RECV` to `ST_IDLE`.
- last reply bit taken, with busy wait requested: `ST_RECV` to `ST_BUSY`.
- DAT0 high on a tick: `ST_BUSY` to `ST_IDLE`.

Top module: `sd_cmd_engine`

## Requirements
- R1: Register map: index 0 is the command word, 1 the argument, 2 the timeout limit, 3 the status, and 4 to 7 the response words 0 to 3. A write to index 0 with bit 15 set while the engine is idle starts a command. Bit 15 of the command word reads 1 from that write until the command has fully finished, and then reads 0.
- R2: The frame is 48 bits sent MSB first on `cmd_out`, one bit per tick, with `cmd_oe` high for exactly those 48 ticks. Its fields are: a 0 start bit, a 1 transmission bit, the index from bits [5:0] of the command word, the 32-bit argument, a CRC7 with polynomial x^7+x^3+1 over the preceding 40 bits, and a 1 end bit. When not sending, `cmd_out` is 1 and `cmd_oe` is 0.
- R3: With the no-response flag (bit 10) set, the command is complete on the tick that sends the last frame bit. No status bit is set.
- R4: Short reply (neither bit 9 nor bit 10 set): 48 bits are taken, starting with the first low bit on `cmd_in`. Response word 0 gets reply bits [39:8] and words 1 to 3 read 0. A CRC7 over reply bits [47:8] that differs from bits [7:1] sets status bit 4 and command-word bit 14.
- R5: Long reply (bit 9 set): 136 bits are taken. Response words 3 to 0 hold reply bits [127:0], with the most significant part in word 3. No CRC check is made.
- R6: The timeout register resets to 0x00F00000. If `cmd_in` stays high for that many ticks while a reply is awaited, status bit 6 and command-word bit 14 are set and the command completes. Bit 14 stays set until the next command starts.
- R7: With the busy flag (bit 11) set and a good reply, bit 15 stays 1 while `dat0_in` is low. On the first tick with `dat0_in` high the command completes and status bit 10 is set.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it. Writing all ones clears every status bit.
- R9: A command-word write while bit 15 reads 1 is ignored: neither the frame in flight nor the stored command word changes.
- R10: The controller state changes only on ticks, apart from the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_tick | input | 1 | Enable marking one SD clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_out | output | 1 | CMD line value when driven |
| cmd_in | input | 1 | CMD line as seen from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |

## Verification
The hardest situation to reach is the exact boundary of the reply timeout. It only exists after a full 48-tick frame has gone out, and then requires a precise count of high ticks on CMD. The bench programs a limit of ten. It holds CMD high for nine ticks and confirms the command is still active, even after idle cycles without ticks. It then gives one more tick and confirms the timeout and failed bits. The busy wait and the ignored mid-frame write are reached the same way: a card model in the bench drives replies bit by bit in step with the ticks, and the extra stimulus is placed at a known tick.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_BUSY
    } eng_state_t;

    // command word fields
    localparam int CW_START  = 15;
    localparam int CW_FAILED = 14;
    localparam int CW_BUSY   = 11;
    localparam int CW_NORSP  = 10;
    localparam int CW_LONG   = 9;

    // status bits
    localparam int SB_CRC  = 4;
    localparam int SB_TMO  = 6;
    localparam int SB_BUSY = 10;

    // register indices
    localparam logic [2:0] RA_CMD = 3'd0;
    localparam logic [2:0] RA_ARG = 3'd1;
    localparam logic [2:0] RA_TMO = 3'd2;
    localparam logic [2:0] RA_STS = 3'd3;

    localparam int FRAME_W = 48;
    localparam int LONG_W  = 136;
    localparam int RSP_W   = 128;

endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [6:0]        crc_o
);
    always_comb begin
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = data_i[i] ^ c[6];
            c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        crc_o = c;
    end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               adv_i,
    output logic               bit_o,
    output logic               last_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (load_i) begin
            shreg_q <= frame_i;
            cnt_q   <= '0;
        end else if (adv_i) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b1};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign bit_o  = shreg_q[FRAME_W-1];
    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int               TMO_W    = 32,
    parameter logic [TMO_W-1:0] TMO_INIT = TMO_W'(32'h00F0_0000)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sd_tick,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cmd_oe,
    output logic        cmd_out,
    input  logic        cmd_in,
    input  logic        dat0_in
);
    localparam int RCNT_W = $clog2(LONG_W);
    localparam logic [RCNT_W-1:0] SHORT_LAST = RCNT_W'(FRAME_W - 1);
    localparam logic [RCNT_W-1:0] LONG_LAST  = RCNT_W'(LONG_W - 1);

    eng_state_t        state_q, state_d;
    logic [13:0]       cmd_q;
    logic              failed_q;
    logic [31:0]       arg_q;
    logic [TMO_W-1:0]  tmo_q, wait_q;
    logic              sts_crc_q, sts_tmo_q, sts_busy_q;
    logic [RSP_W-2:0]  rx_q;
    logic [RCNT_W-1:0] rcnt_q;
    logic [31:0]       rsp_q [4];

    logic              wr_cmd, start, tx_bit, tx_last, tx_adv;
    logic [39:0]       tx_body;
    logic [6:0]        tx_crc, rx_crc;
    logic [RSP_W-1:0]  rx_next;
    logic              rx_done, crc_err, tmo_hit, is_long;

    assign wr_cmd  = reg_wr && (reg_addr == RA_CMD);
    assign start   = wr_cmd && (state_q == ST_IDLE) && reg_wdata[CW_START];
    assign tx_body = {2'b01, reg_wdata[5:0], arg_q};
    assign tx_adv  = (state_q == ST_SEND) && sd_tick;
    assign is_long = cmd_q[CW_LONG];
    assign rx_next = {rx_q, cmd_in};
    assign rx_done = (state_q == ST_RECV) && sd_tick &&
                     (rcnt_q == (is_long ? LONG_LAST : SHORT_LAST));
    assign crc_err = !is_long && (rx_crc != rx_next[7:1]);
    assign tmo_hit = (state_q == ST_WAIT) && sd_tick && cmd_in &&
                     (({1'b0, wait_q} + 1'b1) >= {1'b0, tmo_q});

    sd_crc7 #(.DATA_W(40)) u_tx_crc (.data_i(tx_body), .crc_o(tx_crc));
    sd_crc7 #(.DATA_W(40)) u_rx_crc (.data_i(rx_next[47:8]), .crc_o(rx_crc));

    sd_cmd_tx #(.FRAME_W(FRAME_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start),
        .frame_i({tx_body, tx_crc, 1'b1}),
        .adv_i  (tx_adv),
        .bit_o  (tx_bit),
        .last_o (tx_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (sd_tick && tx_last)
                         state_d = cmd_q[CW_NORSP] ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (sd_tick) begin
                         if (!cmd_in)      state_d = ST_RECV;
                         else if (tmo_hit) state_d = ST_IDLE;
                     end
            ST_RECV: if (rx_done)
                         state_d = (crc_err || !cmd_q[CW_BUSY]) ? ST_IDLE : ST_BUSY;
            ST_BUSY: if (sd_tick && dat0_in) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // register file and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            failed_q   <= 1'b0;
            arg_q      <= '0;
            tmo_q      <= TMO_INIT;
            wait_q     <= '0;
            sts_crc_q  <= 1'b0;
            sts_tmo_q  <= 1'b0;
            sts_busy_q <= 1'b0;
            rx_q       <= '0;
            rcnt_q     <= '0;
            for (int k = 0; k < 4; k++) rsp_q[k] <= '0;
        end else begin
            if (wr_cmd && state_q == ST_IDLE) begin
                cmd_q <= reg_wdata[13:0];
                if (reg_wdata[CW_START]) failed_q <= 1'b0;
            end
            if (reg_wr && reg_addr == RA_ARG) arg_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_TMO) tmo_q <= reg_wdata[TMO_W-1:0];
            if (reg_wr && reg_addr == RA_STS) begin
                if (reg_wdata[SB_CRC])  sts_crc_q  <= 1'b0;
                if (reg_wdata[SB_TMO])  sts_tmo_q  <= 1'b0;
                if (reg_wdata[SB_BUSY]) sts_busy_q <= 1'b0;
            end
            if (state_q == ST_SEND) wait_q <= '0;
            if (state_q == ST_WAIT && sd_tick) begin
                if (cmd_in) begin
                    wait_q <= wait_q + 1'b1;
                end else begin
                    rcnt_q <= RCNT_W'(1);
                    rx_q   <= rx_next[RSP_W-2:0];
                end
            end
            if (tmo_hit) begin
                sts_tmo_q <= 1'b1;
                failed_q  <= 1'b1;
            end
            if (state_q == ST_RECV && sd_tick) begin
                rx_q   <= rx_next[RSP_W-2:0];
                rcnt_q <= rcnt_q + 1'b1;
            end
            if (rx_done) begin
                for (int k = 0; k < 4; k++)
                    rsp_q[k] <= is_long ? rx_next[32*k +: 32]
                                        : ((k == 0) ? rx_next[39:8] : 32'h0);
                if (crc_err) begin
                    sts_crc_q <= 1'b1;
                    failed_q  <= 1'b1;
                end
            end
            if (state_q == ST_BUSY && sd_tick && dat0_in) sts_busy_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_oe  = (state_q == ST_SEND);
        cmd_out = cmd_oe ? tx_bit : 1'b1;
        if (reg_addr[2]) begin
            reg_rdata = rsp_q[reg_addr[1:0]];
        end else begin
            unique case (reg_addr[1:0])
                2'd0: reg_rdata = {16'h0, (state_q != ST_IDLE), failed_q, cmd_q};
                2'd1: reg_rdata = arg_q;
                2'd2: reg_rdata = 32'(tmo_q);
                default: reg_rdata = {21'h0, sts_busy_q, 3'b000, sts_tmo_q,
                                      1'b0, sts_crc_q, 4'h0};
            endcase
        end
    end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk
    import sd_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sd_tick,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        cmd_oe,
    input eng_state_t  state_q,
    input logic [13:0] cmd_q,
    input logic        failed_q,
    input logic        sts_crc_q,
    input logic        sts_tmo_q,
    input logic        sts_busy_q
);
    AST_START_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && reg_wr && reg_addr == RA_CMD && reg_wdata[CW_START])
        |=> (state_q == ST_SEND)); // R1

    AST_DRIVE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> ($past(state_q) == ST_IDLE)); // R2

    AST_CRC_MARKS_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_crc_q) |-> failed_q); // R4

    AST_TMO_MARKS_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_tmo_q) |-> failed_q); // R6

    AST_BUSY_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_busy_q) |-> ($past(state_q) == ST_BUSY)); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && reg_wr && reg_addr == RA_STS && (&reg_wdata))
        |=> !(sts_crc_q || sts_tmo_q || sts_busy_q)); // R8

    AST_IGNORE_ACTIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && reg_wr && reg_addr == RA_CMD) |=> $stable(cmd_q)); // R9

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_tick && !(reg_wr && reg_addr == RA_CMD)) |=> $stable(state_q)); // R10
endmodule

bind sd_cmd_engine sd_cmd_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_tick   (sd_tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmd_oe    (cmd_oe),
    .state_q   (state_q),
    .cmd_q     (cmd_q),
    .failed_q  (failed_q),
    .sts_crc_q (sts_crc_q),
    .sts_tmo_q (sts_tmo_q),
    .sts_busy_q(sts_busy_q)
);

// File: tb/sd_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_oe, cmd_out;
    logic        cmd_in = 1'b1;
    logic        dat0_in = 1'b1;

    int n_checks = 0;
    int n_fail = 0;
    int div = 1;

    always #10 clk = ~clk;

    sd_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_oe(cmd_oe), .cmd_out(cmd_out), .cmd_in(cmd_in), .dat0_in(dat0_in)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [31:0] card;
        logic        bad;
        logic [1:0]  dv;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{6'd13, 32'h0001_0000, 32'h0000_0900, 1'b0, 2'd1},
        '{6'd17, 32'h0000_0200, 32'hDEAD_BEEF, 1'b0, 2'd2},
        '{6'd55, 32'hABCD_0000, 32'h0000_0120, 1'b1, 2'd1},
        '{6'd8,  32'h0000_01AA, 32'h0000_01AA, 1'b0, 2'd3},
        '{6'd41, 32'hFFFF_FFFF, 32'h80FF_8000, 1'b1, 2'd2}
    };

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [46:0] m;
        m = {d, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
        return m[6:0];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sd_tick = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(input logic [2:0] a, input logic tk, output logic [31:0] v);
        @(negedge clk);
        sd_tick = tk; reg_wr = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic step(input logic cin, output logic ob, output logic oe);
        for (int k = 1; k < div; k++) begin
            @(negedge clk);
            reg_wr = 1'b0; sd_tick = 1'b0; cmd_in = cin;
        end
        @(negedge clk);
        reg_wr = 1'b0; sd_tick = 1'b1; cmd_in = cin;
        ob = cmd_out; oe = cmd_oe;
    endtask

    task automatic send(input logic [5:0] idx, input logic [15:0] flags,
                        input logic [31:0] arg, input bit poke, input string tag,
                        output logic [47:0] got);
        logic b, oe, all_oe;
        all_oe = 1'b1;
        wr(3'd1, arg);
        wr(3'd0, {16'h0, 16'h8000 | flags | {10'h0, idx}});
        for (int i = 47; i >= 0; i--) begin
            step(1'b1, b, oe);
            got[i] = b;
            all_oe &= oe;
            if (poke && i == 37) wr(3'd0, 32'h0000_803F);
        end
        chk({tag, " frame"}, got, {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1});
        chk({tag, " cmd_oe during frame"}, all_oe, 1'b1);
    endtask

    task automatic recv(input int len, input logic [135:0] f, input int gap);
        logic b, oe;
        for (int g = 0; g < gap; g++) step(1'b1, b, oe);
        for (int i = len - 1; i >= 0; i--) step(f[i], b, oe);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0]  v;
        logic [47:0]  got;
        logic [135:0] rf;
        logic [6:0]   c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(3'd0, 1'b0, v); chk("R1 reset command word", v, 32'h0);
        rd(3'd2, 1'b0, v); chk("R6 reset timeout", v, 32'h00F0_0000);
        rd(3'd3, 1'b0, v); chk("R8 reset status", v, 32'h0);
        chk("R2 idle line", {cmd_oe, cmd_out}, 2'b01);

        // R3: no-response command, fixed frame value
        send(6'd0, 16'h0400, 32'h0, 1'b0, "R2 R3 cmd0", got);
        chk("R2 cmd0 literal frame", got, 48'h4000_0000_0095);
        rd(3'd0, 1'b0, v); chk("R3 done after frame", v, 32'h0000_0400);
        rd(3'd3, 1'b0, v); chk("R3 no status", v, 32'h0);
        chk("R2 line released", {cmd_oe, cmd_out}, 2'b01);

        // table of short replies (R4, R10 via tick divisor)
        foreach (VECS[n]) begin
            div = int'(VECS[n].dv);
            send(VECS[n].idx, 16'h0, VECS[n].arg, 1'b0, "R2 R10 table", got);
            c = ref_crc({2'b00, VECS[n].idx, VECS[n].card});
            rf = {88'h0, 2'b00, VECS[n].idx, VECS[n].card, c ^ {6'b0, VECS[n].bad}, 1'b1};
            recv(48, rf, n + 1);
            rd(3'd0, 1'b0, v);
            chk("R1 R4 table command word", v, {17'h0, VECS[n].bad, 8'h0, VECS[n].idx});
            rd(3'd3, 1'b0, v);
            chk("R4 table status", v, VECS[n].bad ? 32'h10 : 32'h0);
            rd(3'd4, 1'b0, v); chk("R4 table response 0", v, VECS[n].card);
            rd(3'd5, 1'b0, v); chk("R4 table response 1", v, 32'h0);
            wr(3'd3, 32'hFFFF_FFFF);
        end
        div = 1;

        // R5: long reply, internal CRC field deliberately wrong
        send(6'd2, 16'h0200, 32'h0, 1'b0, "R5 long", got);
        recv(136, {8'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211}, 2);
        rd(3'd0, 1'b0, v); chk("R5 long done", v, 32'h0000_0202);
        rd(3'd3, 1'b0, v); chk("R5 no crc check", v, 32'h0);
        rd(3'd7, 1'b0, v); chk("R5 response 3", v, 32'h0123_4567);
        rd(3'd6, 1'b0, v); chk("R5 response 2", v, 32'h89AB_CDEF);
        rd(3'd5, 1'b0, v); chk("R5 response 1", v, 32'hFEDC_BA98);
        rd(3'd4, 1'b0, v); chk("R5 response 0", v, 32'h7654_3211);

        // R7: busy wait after a good reply
        dat0_in = 1'b0;
        send(6'd12, 16'h0800, 32'h0, 1'b0, "R7 busy", got);
        c = ref_crc({2'b00, 6'd12, 32'h0000_0B00});
        recv(48, {88'h0, 2'b00, 6'd12, 32'h0000_0B00, c, 1'b1}, 1);
        begin
            logic b, oe;
            for (int k = 0; k < 4; k++) step(1'b1, b, oe);
        end
        rd(3'd0, 1'b0, v); chk("R7 active while busy", v[15], 1'b1);
        rd(3'd3, 1'b0, v); chk("R7 no busy status yet", v, 32'h0);
        dat0_in = 1'b1;
        begin
            logic b, oe;
            step(1'b1, b, oe);
        end
        rd(3'd0, 1'b0, v); chk("R7 done on release", v[15], 1'b0);
        rd(3'd3, 1'b0, v); chk("R7 busy status", v, 32'h400);

        // R6: timeout boundary with limit 10
        wr(3'd2, 32'd10);
        send(6'd9, 16'h0, 32'h1234_5678, 1'b0, "R6 timeout", got);
        begin
            logic b, oe;
            for (int k = 0; k < 9; k++) step(1'b1, b, oe);
        end
        repeat (20) rd(3'd0, 1'b0, v);
        chk("R6 R10 still waiting after nine ticks", v[15], 1'b1);
        begin
            logic b, oe;
            step(1'b1, b, oe);
        end
        rd(3'd0, 1'b0, v); chk("R6 failed on tenth tick", v, 32'h0000_4009);
        rd(3'd3, 1'b0, v); chk("R6 R8 timeout plus busy", v, 32'h440);

        // R8: clear one bit, then all
        wr(3'd3, 32'h0000_0040);
        rd(3'd3, 1'b0, v); chk("R8 partial clear", v, 32'h400);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, 1'b0, v); chk("R8 clear all", v, 32'h0);
        rd(3'd0, 1'b0, v); chk("R6 failed sticky", v[14], 1'b1);

        // R9: write during frame ignored; new start clears failed
        send(6'd7, 16'h0400, 32'hCAFE_0001, 1'b1, "R9 poke", got);
        rd(3'd0, 1'b0, v); chk("R9 R6 command word kept", v, 32'h0000_0407);

        finish_run();
    end
endmodule